// File: doc/BRIEF.md
# Clear-on-Read Interrupt Collector

This block gathers event notifications from several independent sources (such as wake-up, over-temperature or bus activity) into one pending register. It requests service from a host by pulling a shared, active-low interrupt line for as long as any pending bit is set. The line works as open-drain: the block only ever pulls it low or lets it go, so several requesters can share one wire with a pull-up.

The host reads the register with a one-cycle read strobe. The value seen in that cycle is latched onto the read-data output and held there until the next read. That same access clears exactly those latched bits. A source edge that lands in the same cycle as the read, or any later cycle, stays pending, so no event is lost between the read and the clear. Each source has an enable. A disabled source never sets its pending bit, but its live level is always visible on a status output. Reporting is the block's only effect: a hot or faulty source never switches anything off.

Top module: `irq_cor_reg`

## Requirements
- R1: While the asynchronous active-low reset is asserted, every pending bit, the read data and the status output are zero, and the interrupt line is released.
- R2: A rising edge on an enabled source level sets that source's pending bit at the next clock edge. A level that stays high sets the bit only once, so after a read clears it, the bit stays clear until the level falls and rises again.
- R3: A rising edge on a source whose enable is low leaves that source's pending bit unchanged.
- R4: `irq_oe_o` is 1 (pull low) and `irq_n_o` is 0 whenever at least one pending bit is set. Otherwise `irq_oe_o` is 0 and `irq_n_o` is 1. The block has no output that drives the line high.
- R5: When `rd_i` is high in a cycle, `rd_data_o` shows, from the next cycle on, the pending bits as they were in that cycle (bit i is source i). It keeps that value until the next read.
- R6: A read clears every pending bit it returned, unless a new edge on that source arrives in the same cycle.
- R7: An enabled edge that arrives in the same cycle as a read is not part of the returned data. It is pending after the read, including when it hits a bit that the read returns.
- R8: `status_o` bit i equals source i's level from the previous clock cycle, whatever the enable.
- R9: Without a read, a pending bit stays set for any number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| src_lvl_i | input | N_SRC | Per-source event level; rising edges are the events |
| src_en_i | input | N_SRC | Per-source interrupt enable |
| rd_i | input | 1 | Read strobe from the host interface, one cycle per access |
| rd_data_o | output | N_SRC | Pending bits captured by the most recent read |
| status_o | output | N_SRC | Registered live level of each source |
| irq_oe_o | output | 1 | Open-drain pull enable: 1 pulls the interrupt line low |
| irq_n_o | output | 1 | Resolved line level, assuming an external pull-up |

## Verification
The hardest case to reach is a source edge that coincides exactly with a read, in particular on the very bit being read. The stimulus first sets a bit and lets its level fall. In a later cycle it raises the read strobe and the same source level together, then checks that the returned data contains the old bit and that the line stays pulled. A second read then shows that the fresh event is still pending. The main sweep walks every enable pattern against every edge pattern on four sources. From those inputs alone the bench computes the pending value, the line state and the read result.

// File: rtl/irq_pkg.sv
package irq_pkg;

  // Drive request towards the open-drain interrupt pad.
  typedef enum logic {
    IRQ_RELEASE = 1'b0,
    IRQ_PULL    = 1'b1
  } irq_drive_e;

  localparam int unsigned IRQ_SRC_DEFAULT = 4;

endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
  parameter int unsigned N_SRC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] lvl_i,
  input  logic [N_SRC-1:0] en_i,
  output logic [N_SRC-1:0] set_o,
  output logic [N_SRC-1:0] lvl_q_o
);

  logic [N_SRC-1:0] lvl_q;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    logic rise;

    always_comb begin
      rise     = lvl_i[g] & ~lvl_q[g];
      set_o[g] = rise & en_i[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lvl_q[g] <= 1'b0;
      end else begin
        lvl_q[g] <= lvl_i[g];
      end
    end
  end

  assign lvl_q_o = lvl_q;

endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
  parameter int unsigned N_SRC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] set_i,
  input  logic             rd_i,
  output logic [N_SRC-1:0] pend_o
);

  logic [N_SRC-1:0] pend_q;
  logic [N_SRC-1:0] pend_d;
  logic [N_SRC-1:0] clr_mask;
  logic             upd_en;

  always_comb begin
    clr_mask = rd_i ? pend_q : '0;
    // A fresh set takes priority over a clear in the same cycle.
    pend_d   = (pend_q & ~clr_mask) | set_i;
    upd_en   = rd_i | (|set_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (upd_en) begin
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/irq_read_port.sv
module irq_read_port #(
  parameter int unsigned N_SRC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_i,
  input  logic [N_SRC-1:0] pend_i,
  output logic [N_SRC-1:0] data_o
);

  logic [N_SRC-1:0] data_q;
  logic [N_SRC-1:0] data_d;

  always_comb begin
    data_d = pend_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (rd_i) begin
      data_q <= data_d;
    end
  end

  assign data_o = data_q;

endmodule

// File: rtl/irq_cor_reg.sv
module irq_cor_reg
  import irq_pkg::*;
#(
  parameter int unsigned N_SRC = IRQ_SRC_DEFAULT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_lvl_i,
  input  logic [N_SRC-1:0] src_en_i,
  input  logic             rd_i,
  output logic [N_SRC-1:0] rd_data_o,
  output logic [N_SRC-1:0] status_o,
  output logic             irq_oe_o,
  output logic             irq_n_o
);

  logic [N_SRC-1:0] set_mask;
  logic [N_SRC-1:0] pend_q;
  irq_drive_e       drive;

  irq_edge_detect #(.N_SRC(N_SRC)) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .lvl_i   (src_lvl_i),
    .en_i    (src_en_i),
    .set_o   (set_mask),
    .lvl_q_o (status_o)
  );

  irq_pend_reg #(.N_SRC(N_SRC)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (set_mask),
    .rd_i   (rd_i),
    .pend_o (pend_q)
  );

  irq_read_port #(.N_SRC(N_SRC)) u_rd (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_i   (rd_i),
    .pend_i (pend_q),
    .data_o (rd_data_o)
  );

  always_comb begin
    drive    = (|pend_q) ? IRQ_PULL : IRQ_RELEASE;
    irq_oe_o = (drive == IRQ_PULL);
    irq_n_o  = ~irq_oe_o;
  end

endmodule

// File: rtl/irq_cor_reg_chk.sv
module irq_cor_reg_chk #(
  parameter int unsigned N_SRC = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] src_lvl_i,
  input logic [N_SRC-1:0] src_en_i,
  input logic             rd_i,
  input logic [N_SRC-1:0] pend,
  input logic [N_SRC-1:0] set,
  input logic [N_SRC-1:0] rd_data_o,
  input logic [N_SRC-1:0] status_o,
  input logic             irq_oe_o,
  input logic             irq_n_o
);

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (pend == '0 && rd_data_o == '0 && status_o == '0 && !irq_oe_o && irq_n_o)
        else $error("reset state not clean");
    end
  end

  assert_enable_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pend & ~$past(pend) & ~$past(src_en_i)) == '0);

  assert_pull_on_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (set != '0) |=> (irq_oe_o && !irq_n_o));

  assert_release_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && set == '0) |=> (!irq_oe_o && irq_n_o));

  assert_rd_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> rd_data_o == $past(pend));

  assert_rd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> $stable(rd_data_o));

  assert_rd_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> (pend & $past(pend) & ~$past(set)) == '0);

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (set != '0) |=> (pend & $past(set)) == $past(set));

  assert_status_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> status_o == $past(src_lvl_i));

  assert_hold_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> (pend & $past(pend)) == $past(pend));

endmodule

bind irq_cor_reg irq_cor_reg_chk #(.N_SRC(N_SRC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .src_lvl_i (src_lvl_i),
  .src_en_i  (src_en_i),
  .rd_i      (rd_i),
  .pend      (pend_q),
  .set       (set_mask),
  .rd_data_o (rd_data_o),
  .status_o  (status_o),
  .irq_oe_o  (irq_oe_o),
  .irq_n_o   (irq_n_o)
);

// File: tb/irq_cor_reg_tb.sv
module irq_cor_reg_tb;

  localparam int unsigned N = 4;

  logic         clk;
  logic         rst_n;
  logic [N-1:0] lvl;
  logic [N-1:0] en;
  logic         rd;
  logic [N-1:0] rd_data;
  logic [N-1:0] status;
  logic         irq_oe;
  logic         irq_n;

  int checks;
  int fails;

  irq_cor_reg #(.N_SRC(N)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_lvl_i (lvl),
    .src_en_i  (en),
    .rd_i      (rd),
    .rd_data_o (rd_data),
    .status_o  (status),
    .irq_oe_o  (irq_oe),
    .irq_n_o   (irq_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_read();
    rd = 1'b1;
    tick();
    rd = 1'b0;
  endtask

  task automatic chk_line(input string req, input bit pending);
    chk(req, int'(irq_oe), int'(pending));
    chk(req, int'(irq_n), int'(!pending));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    checks = 0;
    fails  = 0;
    rst_n  = 1'b0;
    lvl    = '0;
    en     = '0;
    rd     = 1'b0;
    repeat (3) tick();
    // R1: reset state
    chk("R1 rd_data", int'(rd_data), 0);
    chk("R1 status", int'(status), 0);
    chk_line("R1 line", 1'b0);
    rst_n = 1'b1;
    tick();

    // Sweep every enable pattern against every edge pattern.
    for (int e = 0; e < 16; e++) begin
      for (int p = 0; p < 16; p++) begin
        en  = N'(e);
        lvl = N'(p);
        tick();
        chk("R8 status", int'(status), p);
        chk_line("R2/R3/R4 line after edge", (p & e) != 0);
        lvl = '0;
        tick();
        chk_line("R9 still pending", (p & e) != 0);
        do_read();
        chk("R2/R3/R5 read data", int'(rd_data), p & e);
        chk_line("R6 cleared by read", 1'b0);
        tick();
        chk("R5 data held", int'(rd_data), p & e);
      end
    end

    // R2: held level sets once only.
    en  = 4'hF;
    lvl = 4'b0001;
    tick();
    do_read();
    chk("R2 first read", int'(rd_data), 1);
    repeat (5) tick();
    chk_line("R2 no re-set while held", 1'b0);
    do_read();
    chk("R2 second read", int'(rd_data), 0);

    // R7: edge on another bit in the read cycle.
    lvl = '0;
    tick();
    lvl = 4'b0001;
    tick();
    lvl = 4'b0011;
    do_read();
    chk("R7 other bit not in data", int'(rd_data), 1);
    chk_line("R7 other bit pending", 1'b1);
    do_read();
    chk("R7 other bit read later", int'(rd_data), 2);

    // R7: edge on the very bit being read.
    lvl = '0;
    tick();
    lvl = 4'b0001;
    tick();
    lvl = '0;
    tick();
    lvl = 4'b0001;
    do_read();
    chk("R7 same bit returned", int'(rd_data), 1);
    chk_line("R7 same bit stays set", 1'b1);
    do_read();
    chk("R7 same bit read again", int'(rd_data), 1);
    chk_line("R6 clear after collision", 1'b0);

    // R9: long persistence.
    lvl = '0;
    tick();
    lvl = 4'b1000;
    tick();
    repeat (30) tick();
    chk_line("R9 long hold", 1'b1);
    do_read();
    chk("R9 read after hold", int'(rd_data), 8);

    // R3 and R8: disabled sources toggle, status follows.
    en = '0;
    for (int k = 0; k < 6; k++) begin
      lvl = (k % 2 == 0) ? 4'hF : 4'h0;
      tick();
      chk("R8 status disabled", int'(status), int'(lvl));
      chk_line("R3 disabled no irq", 1'b0);
    end
    do_read();
    chk("R3 disabled read", int'(rd_data), 0);

    // R1: reset in mid-run.
    en  = 4'hF;
    lvl = '0;
    tick();
    lvl = 4'b0110;
    tick();
    do_read();
    lvl = 4'b1001;
    tick();
    chk_line("R1 pending before reset", 1'b1);
    rst_n = 1'b0;
    tick();
    chk_line("R1 line after reset", 1'b0);
    chk("R1 rd_data after reset", int'(rd_data), 0);
    chk("R1 status after reset", int'(status), 0);
    lvl   = '0;
    rst_n = 1'b1;
    tick();
    do_read();
    chk("R1 nothing pending after reset", int'(rd_data), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule